// File: doc/BRIEF.md
# Two-Wire Target with a 16-Bit Register Map

This block is a two-wire (I2C) target for bus rates up to 400 kHz, clocked from a faster system clock. Both bus lines are brought through two-flop synchronisers and their edges are found on the system clock. START, repeated START and STOP are recognised, and the 7-bit target address is matched. Every byte the target accepts is acknowledged by pulling SDA low through an open-drain enable. Reads return bytes from a small map of 16-bit registers, high byte at the even byte address. The byte pointer advances after every byte.

Writes are assembled into whole 16-bit words before anything changes. A word whose second byte never arrives leaves no trace. Two write-only command locations are decoded: one magic word raises a one-cycle quick-start pulse, and another restores the block to its power-up state and withholds the acknowledge for its final byte. The measured cell voltage and charge level enter as plain inputs. The configuration word leaves as an output.

Top module: `i2c_reg16_slave`

## Requirements
- R1: The target acknowledges only address bytes whose upper seven bits equal 0110110 (6Ch for write, 6Dh for read, bit 0 being the direction). For any other address it never drives SDA until the next START.
- R2: Reads send MSb first. Byte 02h returns voltage input bits 11:4 and byte 03h returns voltage bits 3:0 followed by four zero bits. Bytes 04h/05h return the charge input high/low byte and 08h/09h the version constant high/low byte. The pointer advances one byte per transferred byte.
- R3: The configuration word (bytes 0Ch high, 0Dh low) resets to 971Ch and is readable and writable. Bit 5 of its low byte keeps its reset value 0 whatever is written.
- R4: A write changes a register only once both of its bytes have been received in the same transfer. A transfer that stops after the high byte leaves the register unchanged.
- R5: Data written to read-only, reserved or write-only-without-effect locations changes no readable state. A lone byte written at an odd address is discarded.
- R6: Once a write transfer auto-increments past byte 4Fh, every later data byte of that transfer is still acknowledged but discarded, even one that reaches the command location.
- R7: Reads of reserved or write-only bytes return 00h. Reads with the pointer past FFh return FFh.
- R8: Writing the word 4000h to bytes 06h/07h produces exactly one single-cycle quick-start pulse. Any other word there produces none.
- R9: Writing 5400h to bytes FEh/FFh produces a single-cycle reset pulse and returns the configuration to 971Ch. The target does not acknowledge that final byte and goes idle.
- R10: A repeated START keeps the byte pointer set by the preceding write. After the controller's NAK in a read, the target releases SDA.
- R11: After reset SDA is released, the configuration reads 971Ch and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain) |
| vcell_i | input | 12 | Measured cell voltage code |
| soc_i | input | 16 | Charge level, percent in high byte |
| config_o | output | 16 | Current configuration word |
| qstart_o | output | 1 | One-cycle quick-start request |
| soft_reset_o | output | 1 | One-cycle full-reset request |

## Verification
The read path is tried with a table of two-byte reads over data, configuration, write-only and reserved locations, so that a wrong byte order, a missing zero fill or a stale mux entry each show as a distinct value. Writes are tried whole, cut after one byte, started on an odd byte, aimed at read-only words, and run as one long burst from 4Eh to FFh. This tells word assembly apart from per-byte commits and shows that the past-4Fh block holds even at the command word. Magic and near-magic command words separate the value decode from the address decode. A read that crosses FFh and a read that ends with a NAK exercise the pointer saturation and the release of SDA.

// File: rtl/i2c_reg16_pkg.sv
package i2c_reg16_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = BYTE_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_WAIT
  } bus_state_e;

  typedef enum logic [1:0] {
    BK_DEV, BK_REG, BK_DATA
  } byte_kind_e;

  localparam logic [7:0] A_VOLT_HI = 8'h02;
  localparam logic [7:0] A_VOLT_LO = 8'h03;
  localparam logic [7:0] A_CHG_HI  = 8'h04;
  localparam logic [7:0] A_CHG_LO  = 8'h05;
  localparam logic [7:0] A_QS_LO   = 8'h07;
  localparam logic [7:0] A_VER_HI  = 8'h08;
  localparam logic [7:0] A_VER_LO  = 8'h09;
  localparam logic [7:0] A_CFG_HI  = 8'h0C;
  localparam logic [7:0] A_CFG_LO  = 8'h0D;
  localparam logic [7:0] A_RST_LO  = 8'hFF;
  localparam logic [7:0] A_WR_LAST = 8'h4F;

  localparam logic [15:0] QS_WORD  = 16'h4000;
  localparam logic [15:0] RST_WORD = 16'h5400;
  localparam int CFG_LOCK_BIT = 5;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] cur;
  logic [LINES-1:0] prv;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] pipe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '1;
      else        pipe_q <= {pipe_q[STAGES-1:0], raw[g]};
    end
    assign cur[g] = pipe_q[STAGES-1];
    assign prv[g] = pipe_q[STAGES];
  end

  assign sda_o      = cur[1];
  assign scl_rise_o = cur[0] & ~prv[0];
  assign scl_fall_o = ~cur[0] & prv[0];
  assign start_o    = cur[0] & prv[0] & prv[1] & ~cur[1];
  assign stop_o     = cur[0] & prv[0] & ~prv[1] & cur[1];
endmodule

// File: rtl/i2c_reg16_engine.sv
module i2c_reg16_engine
  import i2c_reg16_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_q,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_byte,
  input  logic             por_hit,
  output logic             byte_stb,
  output logic [7:0]       byte_addr,
  output logic [7:0]       byte_data,
  output logic             byte_ok,
  output logic             frame_clr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             sda_oe
);
  bus_state_e state_q, state_d;
  byte_kind_e kind_q, kind_d;
  logic             rw_q, rw_d;
  logic [3:0]       cnt_q, cnt_d;
  logic [7:0]       sh_q, sh_d;
  logic [7:0]       tx_q, tx_d;
  logic             oe_q, oe_d;
  logic             mack_q, mack_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             blk_q, blk_d;
  logic             eval;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return p[PTR_W-1] ? p : p + 1'b1;
  endfunction

  assign eval      = (state_q == ST_RX) && scl_fall && (cnt_q == 4'd8);
  assign byte_stb  = eval && (kind_q == BK_DATA);
  assign byte_addr = ptr_q[7:0];
  assign byte_data = sh_q;
  assign byte_ok   = ~blk_q & ~ptr_q[PTR_W-1];
  assign frame_clr = start_det | stop_det;
  assign rd_ptr    = ptr_q;
  assign sda_oe    = oe_q;

  always_comb begin
    state_d = state_q; kind_d = kind_q; rw_d = rw_q; cnt_d = cnt_q;
    sh_d = sh_q; tx_d = tx_q; oe_d = oe_q; mack_d = mack_q;
    ptr_d = ptr_q; blk_d = blk_q;
    if (start_det) begin
      state_d = ST_RX; kind_d = BK_DEV; cnt_d = '0; oe_d = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE; oe_d = 1'b0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise && cnt_q != 4'd8) begin
            sh_d  = {sh_q[6:0], sda_q};
            cnt_d = cnt_q + 4'd1;
          end
          if (eval) begin
            case (kind_q)
              BK_DEV: begin
                if (sh_q[7:1] == DEV_ADDR) begin
                  rw_d = sh_q[0]; oe_d = 1'b1; state_d = ST_RX_ACK;
                end else begin
                  state_d = ST_WAIT;
                end
              end
              BK_REG: begin
                ptr_d = {1'b0, sh_q}; blk_d = 1'b0;
                oe_d = 1'b1; state_d = ST_RX_ACK;
              end
              default: begin
                if (por_hit) begin
                  state_d = ST_IDLE; oe_d = 1'b0; ptr_d = '0; blk_d = 1'b0;
                end else begin
                  if (ptr_q == {1'b0, A_WR_LAST}) blk_d = 1'b1;
                  ptr_d = bump(ptr_q);
                  oe_d = 1'b1; state_d = ST_RX_ACK;
                end
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (kind_q == BK_DEV && rw_q) begin
              state_d = ST_TX; tx_d = rd_byte; oe_d = ~rd_byte[7];
            end else begin
              oe_d = 1'b0; state_d = ST_RX;
              kind_d = (kind_q == BK_DEV) ? BK_REG : BK_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              oe_d = 1'b0; state_d = ST_TX_ACK; ptr_d = bump(ptr_q);
            end else begin
              cnt_d = cnt_q + 4'd1;
              tx_d  = {tx_q[6:0], 1'b0};
              oe_d  = ~tx_q[6];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) mack_d = ~sda_q;
          if (scl_fall) begin
            if (mack_q) begin
              state_d = ST_TX; cnt_d = '0; tx_d = rd_byte; oe_d = ~rd_byte[7];
            end else begin
              state_d = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; kind_q <= BK_DEV; rw_q <= 1'b0; cnt_q <= '0;
      sh_q <= '0; tx_q <= '0; oe_q <= 1'b0; mack_q <= 1'b0;
      ptr_q <= '0; blk_q <= 1'b0;
    end else begin
      state_q <= state_d; kind_q <= kind_d; rw_q <= rw_d; cnt_q <= cnt_d;
      sh_q <= sh_d; tx_q <= tx_d; oe_q <= oe_d; mack_q <= mack_d;
      ptr_q <= ptr_d; blk_q <= blk_d;
    end
  end

  // R9: the magic reset word gets no acknowledge and leaves the engine idle
  assert_reset_nak_R9: assert property (@(posedge clk) disable iff (!rst_n)
    por_hit |=> (state_q == ST_IDLE && !sda_oe));

  // R1: SDA is only ever pulled during an acknowledge slot or a data send
  assert_drive_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (state_q == ST_RX_ACK || state_q == ST_TX));

  // R10: a controller NAK ends the read with SDA released
  assert_nak_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TX_ACK && scl_fall && !mack_q) |=> (state_q == ST_WAIT && !sda_oe));

  // R11: no drive while idle
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_oe);
endmodule

// File: rtl/i2c_reg16_regfile.sv
module i2c_reg16_regfile
  import i2c_reg16_pkg::*;
#(
  parameter int          VCELL_W   = 12,
  parameter logic [15:0] CFG_RESET = 16'h971C,
  parameter logic [15:0] VERSION   = 16'h0012
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               byte_stb,
  input  logic [7:0]         byte_addr,
  input  logic [7:0]         byte_data,
  input  logic               byte_ok,
  input  logic               frame_clr,
  input  logic [PTR_W-1:0]   rd_ptr,
  input  logic [VCELL_W-1:0] vcell_i,
  input  logic [15:0]        soc_i,
  output logic [7:0]         rd_byte,
  output logic               por_hit,
  output logic [15:0]        config_o,
  output logic               qstart_o,
  output logic               soft_reset_o
);
  localparam int PAD_W = 16 - VCELL_W;

  logic [7:0]  hi_q, hi_d;
  logic        hv_q, hv_d;
  logic [15:0] cfg_q, cfg_d;
  logic        qs_q, rs_q;
  logic        commit, qs_hit, cfg_we;
  logic [15:0] word, volt_word;

  assign volt_word = {vcell_i, {PAD_W{1'b0}}};
  assign commit    = byte_stb & byte_ok & byte_addr[0] & hv_q;
  assign word      = {hi_q, byte_data};
  assign por_hit   = commit && (byte_addr == A_RST_LO) && (word == RST_WORD);
  assign qs_hit    = commit && (byte_addr == A_QS_LO) && (word == QS_WORD);
  assign cfg_we    = commit && (byte_addr == A_CFG_LO);

  always_comb begin
    hi_d = hi_q;
    hv_d = hv_q;
    if (frame_clr || por_hit) begin
      hv_d = 1'b0;
    end else if (byte_stb) begin
      if (!byte_addr[0]) begin
        hi_d = byte_data;
        hv_d = byte_ok;
      end else begin
        hv_d = 1'b0;
      end
    end
    cfg_d = cfg_q;
    if (por_hit) begin
      cfg_d = CFG_RESET;
    end else if (cfg_we) begin
      cfg_d = word;
      cfg_d[CFG_LOCK_BIT] = cfg_q[CFG_LOCK_BIT];
    end
  end

  always_comb begin
    rd_byte = 8'h00;
    if (rd_ptr[PTR_W-1]) begin
      rd_byte = 8'hFF;
    end else begin
      case (rd_ptr[7:0])
        A_VOLT_HI: rd_byte = volt_word[15:8];
        A_VOLT_LO: rd_byte = volt_word[7:0];
        A_CHG_HI:  rd_byte = soc_i[15:8];
        A_CHG_LO:  rd_byte = soc_i[7:0];
        A_VER_HI:  rd_byte = VERSION[15:8];
        A_VER_LO:  rd_byte = VERSION[7:0];
        A_CFG_HI:  rd_byte = cfg_q[15:8];
        A_CFG_LO:  rd_byte = cfg_q[7:0];
        default:   rd_byte = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0; hv_q <= 1'b0; cfg_q <= CFG_RESET; qs_q <= 1'b0; rs_q <= 1'b0;
    end else begin
      hi_q <= hi_d; hv_q <= hv_d; cfg_q <= cfg_d; qs_q <= qs_hit; rs_q <= por_hit;
    end
  end

  assign config_o     = cfg_q;
  assign qstart_o     = qs_q;
  assign soft_reset_o = rs_q;

  // R8: quick-start and full reset never fire together
  assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({qs_q, rs_q}));

  // R8: a completed magic word at the quick-start location yields the pulse next cycle
  assert_qstart_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    qs_hit |=> qs_q);

  // R9: the reset pulse coincides with the restored configuration
  assert_reset_restores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rs_q |-> (cfg_q == CFG_RESET));

  // R3: the locked configuration bit never moves
  assert_lock_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[CFG_LOCK_BIT] == CFG_RESET[CFG_LOCK_BIT]);

  // R4: the configuration changes only on a whole-word commit or a reset command
  assert_word_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we || por_hit) |=> $stable(cfg_q));
endmodule

// File: rtl/i2c_reg16_slave.sv
module i2c_reg16_slave
  import i2c_reg16_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h36,
  parameter logic [15:0] CFG_RESET   = 16'h971C,
  parameter logic [15:0] VERSION     = 16'h0012,
  parameter int          VCELL_W     = 12,
  parameter int          SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [VCELL_W-1:0] vcell_i,
  input  logic [15:0]        soc_i,
  output logic [15:0]        config_o,
  output logic               qstart_o,
  output logic               soft_reset_o
);
  logic [1:0]       rst_pipe_q;
  logic             core_rst_n;
  logic             sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic             byte_stb, byte_ok, frame_clr, por_hit;
  logic [7:0]       byte_addr, byte_data, rd_byte;
  logic [PTR_W-1:0] rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(core_rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_q), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_reg16_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk(clk), .rst_n(core_rst_n), .sda_q(sda_q),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_byte(rd_byte), .por_hit(por_hit),
    .byte_stb(byte_stb), .byte_addr(byte_addr), .byte_data(byte_data),
    .byte_ok(byte_ok), .frame_clr(frame_clr), .rd_ptr(rd_ptr),
    .sda_oe(sda_oe_o)
  );

  i2c_reg16_regfile #(
    .VCELL_W(VCELL_W), .CFG_RESET(CFG_RESET), .VERSION(VERSION)
  ) u_regs (
    .clk(clk), .rst_n(core_rst_n),
    .byte_stb(byte_stb), .byte_addr(byte_addr), .byte_data(byte_data),
    .byte_ok(byte_ok), .frame_clr(frame_clr), .rd_ptr(rd_ptr),
    .vcell_i(vcell_i), .soc_i(soc_i),
    .rd_byte(rd_byte), .por_hit(por_hit), .config_o(config_o),
    .qstart_o(qstart_o), .soft_reset_o(soft_reset_o)
  );
endmodule

// File: tb/tb_i2c_reg16_slave.sv
`timescale 1ns/1ps
module tb_i2c_reg16_slave;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [11:0] vcell = 12'hABC;
  logic [15:0] soc = 16'h5A3C;
  logic [15:0] cfg;
  logic qs, srst;

  int n_chk = 0, n_fail = 0, qs_cnt = 0, rs_cnt = 0, ack_cnt = 0;
  logic last_ack;
  logic [7:0] rd_buf [8];

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_reg16_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .vcell_i(vcell), .soc_i(soc),
    .config_o(cfg), .qstart_o(qs), .soft_reset_o(srst)
  );

  always @(posedge clk) begin
    if (qs) qs_cnt++;
    if (srst) rs_cnt++;
  end

  localparam logic [23:0] RD_TAB [7] = '{
    {8'h02, 16'hABC0}, {8'h04, 16'h5A3C}, {8'h08, 16'h0012},
    {8'h0C, 16'h971C}, {8'h06, 16'h0000}, {8'h0A, 16'h0000},
    {8'hFE, 16'h0000}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b0; tick(HALF); scl_m = 1'b0; tick(2);
  endtask

  task automatic bus_rstart;
    sda_m = 1'b1; tick(HALF); scl_m = 1'b1; tick(HALF);
    sda_m = 1'b0; tick(HALF); scl_m = 1'b0; tick(2);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(HALF); scl_m = 1'b1; tick(HALF); sda_m = 1'b1; tick(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(HALF); scl_m = 1'b1; tick(HALF); scl_m = 1'b0; tick(2);
    end
    sda_m = 1'b1; tick(HALF); scl_m = 1'b1; tick(HALF/2);
    last_ack = ~sda_line;
    if (last_ack) ack_cnt++;
    tick(HALF/2); scl_m = 1'b0; tick(2);
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tick(HALF); scl_m = 1'b1; tick(HALF/2); b[i] = sda_line;
      tick(HALF/2); scl_m = 1'b0; tick(2);
    end
    sda_m = ~ack; tick(HALF); scl_m = 1'b1; tick(HALF); scl_m = 1'b0; tick(2);
    sda_m = 1'b1;
  endtask

  task automatic write_word(input logic [7:0] addr, input logic [15:0] w);
    ack_cnt = 0;
    bus_start; send_byte(8'h6C); send_byte(addr);
    send_byte(w[15:8]); send_byte(w[7:0]); bus_stop;
  endtask

  task automatic read_bytes(input logic [7:0] addr, input int n);
    logic [7:0] b;
    bus_start; send_byte(8'h6C); send_byte(addr);
    bus_rstart; send_byte(8'h6D);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      rd_buf[k] = b;
    end
    tick(4);
    chk("R10 sda released after NAK", {31'd0, sda_oe}, 32'd0);
    bus_stop;
  endtask

  initial begin
    tick(200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tick(5); rst_n = 1'b1; tick(5);
    // R11 reset state
    chk("R11 sda idle", {31'd0, sda_oe}, 32'd0);
    chk("R11 config reset", {16'd0, cfg}, 32'h971C);
    chk("R11 pulses low", {30'd0, qs, srst}, 32'd0);

    // table of reads: R2 data, R3 config, R7 write-only/reserved
    for (int t = 0; t < 7; t++) begin
      read_bytes(RD_TAB[t][23:16], 2);
      chk((RD_TAB[t][23:16] == 8'h0C) ? "R3 table read" :
          (RD_TAB[t][23:16] <= 8'h08 && RD_TAB[t][23:16] != 8'h06) ? "R2 table read" :
          "R7 table read", {16'd0, rd_buf[0], rd_buf[1]}, {16'd0, RD_TAB[t][15:0]});
    end

    // R2 auto-increment across two registers
    read_bytes(8'h02, 4);
    chk("R2 burst read", {rd_buf[0], rd_buf[1], rd_buf[2], rd_buf[3]}, 32'hABC05A3C);

    // R1 foreign address
    ack_cnt = 0;
    bus_start; send_byte(8'hA0); send_byte(8'h0C); bus_stop;
    chk("R1 foreign address ignored", ack_cnt, 0);
    ack_cnt = 0;
    bus_start; send_byte(8'h6C); bus_stop;
    chk("R1 own address acked", ack_cnt, 1);

    // R4 cut-short write
    ack_cnt = 0;
    bus_start; send_byte(8'h6C); send_byte(8'h0C); send_byte(8'h12); bus_stop;
    chk("R4 partial write discarded", {16'd0, cfg}, 32'h971C);

    // R5 read-only write and lone odd byte
    write_word(8'h04, 16'h1234);
    read_bytes(8'h04, 2);
    chk("R5 read-only untouched", {16'd0, rd_buf[0], rd_buf[1]}, 32'h5A3C);
    bus_start; send_byte(8'h6C); send_byte(8'h0D); send_byte(8'h00); bus_stop;
    chk("R5 odd byte discarded", {16'd0, cfg}, 32'h971C);

    // R3 full write with locked bit, read back through repeated start
    write_word(8'h0C, 16'hA5FF);
    chk("R3 write acked", ack_cnt, 4);
    chk("R3 config written", {16'd0, cfg}, 32'hA5DF);
    read_bytes(8'h0C, 4);
    chk("R10 read after repeated start", {rd_buf[0], rd_buf[1], rd_buf[2], rd_buf[3]}, 32'hA5DF0000);

    // R7 pointer past FFh
    read_bytes(8'hFE, 4);
    chk("R7 read past end", {rd_buf[0], rd_buf[1], rd_buf[2], rd_buf[3]}, 32'h0000FFFF);

    // R8 quick-start decode
    write_word(8'h06, 16'h4000); tick(4);
    chk("R8 quick-start pulse", qs_cnt, 1);
    write_word(8'h06, 16'h4001); tick(4);
    chk("R8 near-magic ignored", qs_cnt, 1);

    // R6 burst beyond 4Fh reaching the reset word
    ack_cnt = 0;
    bus_start; send_byte(8'h6C); send_byte(8'h4E);
    for (int a = 8'h4E; a <= 8'hFF; a++)
      send_byte((a == 8'hFE) ? 8'h54 : 8'h00);
    bus_stop;
    chk("R6 all burst bytes acked", ack_cnt, 2 + 178);
    chk("R6 no reset from blocked data", rs_cnt, 0);
    chk("R6 config kept", {16'd0, cfg}, 32'hA5DF);

    // R9 reset command
    ack_cnt = 0;
    bus_start; send_byte(8'h6C); send_byte(8'hFE); send_byte(8'h54);
    chk("R9 high byte acked", {31'd0, last_ack}, 32'd1);
    send_byte(8'h00);
    chk("R9 last byte not acked", {31'd0, last_ack}, 32'd0);
    bus_stop;
    chk("R9 reset pulse", rs_cnt, 1);
    chk("R9 config restored", {16'd0, cfg}, 32'h971C);
    read_bytes(8'h0C, 2);
    chk("R9 readable after reset", {16'd0, rd_buf[0], rd_buf[1]}, 32'h971C);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule